// File: doc/BRIEF.md
# Register Value Break Comparator

This block watches the architectural state of a small CPU at instruction retirement and raises a debug break request when that state matches a programmed condition. Each time the CPU retires an instruction, it presents a snapshot of its post-execution state on the block's inputs: two 4-bit accumulators (A, B), four status flags (E, I, C, Z) and two 16-bit index registers (X, Y). The block compares every snapshot bit against a programmed compare value. A mask bit of 1 removes that bit from the compare.

The break request fires only when every field that is not masked matches. The field results are ANDed together. The request is a registered one-cycle pulse that appears the cycle after the retire strobe, so it lines up with "just after the instruction executed". Only one condition is held at a time, and a global enable gates the whole function. Halting the CPU is left to the logic that consumes the pulse.

Top module: `regval_break`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `brk_req` is 0.
- R2: The comparison is evaluated only in a cycle where `retire` is 1; a matching snapshot with `retire` at 0 never produces a pulse.
- R3: Each bit of `snap_a`/`snap_b` whose mask bit (`msk_a`/`msk_b`) is 0 must equal the same bit of `cmp_a`/`cmp_b` for a match.
- R4: Flags are packed as bit 3 = E, bit 2 = I, bit 1 = C, bit 0 = Z; each flag whose `msk_flg` bit is 0 must equal `cmp_flg` at that position.
- R5: Each bit of `snap_x`/`snap_y` whose mask bit is 0 must equal the matching bit of `cmp_x`/`cmp_y`.
- R6: A bit whose mask bit is 1 always matches, whatever its snapshot and compare values are.
- R7: The break condition is the AND of all field matches: a single unmasked mismatch in any field suppresses the pulse.
- R8: With `enable` at 1 and every mask bit at 1, every retired instruction produces a pulse.
- R9: While `enable` is 0 at the retire edge, `brk_req` stays 0 in the following cycle.
- R10: A qualifying retire in cycle n gives `brk_req` = 1 in cycle n+1 only. Back-to-back qualifying retires give back-to-back pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Enables the break condition |
| retire | input | 1 | Instruction retire strobe; snapshot valid |
| snap_a | input | 4 | Retired A register |
| snap_b | input | 4 | Retired B register |
| snap_flg | input | 4 | Retired flags {E,I,C,Z} |
| snap_x | input | 16 | Retired X register |
| snap_y | input | 16 | Retired Y register |
| cmp_a | input | 4 | Compare value for A |
| cmp_b | input | 4 | Compare value for B |
| cmp_flg | input | 4 | Compare value for flags |
| cmp_x | input | 16 | Compare value for X |
| cmp_y | input | 16 | Compare value for Y |
| msk_a | input | 4 | Mask for A (1 = ignore bit) |
| msk_b | input | 4 | Mask for B (1 = ignore bit) |
| msk_flg | input | 4 | Mask for flags (1 = ignore flag) |
| msk_x | input | 16 | Mask for X (1 = ignore bit) |
| msk_y | input | 16 | Mask for Y (1 = ignore bit) |
| brk_req | output | 1 | One-cycle break request pulse |

## Verification
The bench drives snapshots that differ from the compare value in exactly one bit, in each field and at the top and bottom bits. A design that ORed the fields, or dropped a field from the AND, would pulse on those snapshots. It also sets the mask on exactly the mismatching bit. A design with inverted mask polarity would then miss the break, and one that ignored masks would fail the all-masked case. Matching snapshots presented with the strobe low or the block disabled expose a comparator that is not gated. Back-to-back retires expose an output that stretches into a level or drops every second pulse.

// File: rtl/regval_break_pkg.sv
package regval_break_pkg;
   localparam int unsigned FLG_W  = 4;
   localparam int unsigned FLG_E  = 3;
   localparam int unsigned FLG_I  = 2;
   localparam int unsigned FLG_C  = 1;
   localparam int unsigned FLG_Z  = 0;
   localparam int unsigned NFIELD = 5;
   typedef enum logic [2:0] {
      FLD_A = 3'd0, FLD_B = 3'd1, FLD_F = 3'd2, FLD_X = 3'd3, FLD_Y = 3'd4
   } field_e;
endpackage

// File: rtl/rvb_field_cmp.sv
module rvb_field_cmp #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] snap,
   input  logic [W-1:0] cmp,
   input  logic [W-1:0] msk,
   output logic         hit
);
   generate
      if (W < 1) begin : g_bad_w
         $error("rvb_field_cmp: W must be at least 1");
      end
      if (W == 1) begin : g_single
         assign hit = msk[0] | (snap[0] == cmp[0]);
      end else begin : g_multi
         logic [W-1:0] bit_ok;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign bit_ok[i] = msk[i] | ~(snap[i] ^ cmp[i]);
         end
         assign hit = &bit_ok;
      end
   endgenerate
endmodule

// File: rtl/rvb_pulse_reg.sv
module rvb_pulse_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic pulse
);
   always_ff @(posedge clk) begin
      if (!rst_n) pulse <= 1'b0;
      else        pulse <= fire;
   end
endmodule

// File: rtl/regval_break.sv
module regval_break
   import regval_break_pkg::*;
#(
   parameter int unsigned ACC_W = 4,
   parameter int unsigned IDX_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             retire,
   input  logic [ACC_W-1:0] snap_a,
   input  logic [ACC_W-1:0] snap_b,
   input  logic [FLG_W-1:0] snap_flg,
   input  logic [IDX_W-1:0] snap_x,
   input  logic [IDX_W-1:0] snap_y,
   input  logic [ACC_W-1:0] cmp_a,
   input  logic [ACC_W-1:0] cmp_b,
   input  logic [FLG_W-1:0] cmp_flg,
   input  logic [IDX_W-1:0] cmp_x,
   input  logic [IDX_W-1:0] cmp_y,
   input  logic [ACC_W-1:0] msk_a,
   input  logic [ACC_W-1:0] msk_b,
   input  logic [FLG_W-1:0] msk_flg,
   input  logic [IDX_W-1:0] msk_x,
   input  logic [IDX_W-1:0] msk_y,
   output logic             brk_req
);
   generate
      if (ACC_W < 1 || ACC_W > 64) begin : g_bad_acc
         $error("regval_break: ACC_W out of range");
      end
      if (IDX_W < 1 || IDX_W > 64) begin : g_bad_idx
         $error("regval_break: IDX_W out of range");
      end
   endgenerate

   logic [NFIELD-1:0] fld_hit;
   logic              cond_met;

   rvb_field_cmp #(.W(ACC_W)) u_cmp_a (
      .snap(snap_a), .cmp(cmp_a), .msk(msk_a), .hit(fld_hit[FLD_A]));
   rvb_field_cmp #(.W(ACC_W)) u_cmp_b (
      .snap(snap_b), .cmp(cmp_b), .msk(msk_b), .hit(fld_hit[FLD_B]));
   rvb_field_cmp #(.W(FLG_W)) u_cmp_f (
      .snap(snap_flg), .cmp(cmp_flg), .msk(msk_flg), .hit(fld_hit[FLD_F]));
   rvb_field_cmp #(.W(IDX_W)) u_cmp_x (
      .snap(snap_x), .cmp(cmp_x), .msk(msk_x), .hit(fld_hit[FLD_X]));
   rvb_field_cmp #(.W(IDX_W)) u_cmp_y (
      .snap(snap_y), .cmp(cmp_y), .msk(msk_y), .hit(fld_hit[FLD_Y]));

   assign cond_met = enable & retire & (&fld_hit);

   rvb_pulse_reg u_pulse (
      .clk(clk), .rst_n(rst_n), .fire(cond_met), .pulse(brk_req));
endmodule

// File: rtl/regval_break_chk.sv
module regval_break_chk
   import regval_break_pkg::*;
#(
   parameter int unsigned ACC_W = 4,
   parameter int unsigned IDX_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enable,
   input logic             retire,
   input logic [ACC_W-1:0] snap_a,
   input logic [ACC_W-1:0] snap_b,
   input logic [FLG_W-1:0] snap_flg,
   input logic [IDX_W-1:0] snap_x,
   input logic [IDX_W-1:0] snap_y,
   input logic [ACC_W-1:0] cmp_a,
   input logic [ACC_W-1:0] cmp_b,
   input logic [FLG_W-1:0] cmp_flg,
   input logic [IDX_W-1:0] cmp_x,
   input logic [IDX_W-1:0] cmp_y,
   input logic [ACC_W-1:0] msk_a,
   input logic [ACC_W-1:0] msk_b,
   input logic [FLG_W-1:0] msk_flg,
   input logic [IDX_W-1:0] msk_x,
   input logic [IDX_W-1:0] msk_y,
   input logic             brk_req
);
   logic diff_any, all_msk;
   assign diff_any = (|((snap_a ^ cmp_a) & ~msk_a)) | (|((snap_b ^ cmp_b) & ~msk_b))
                   | (|((snap_flg ^ cmp_flg) & ~msk_flg))
                   | (|((snap_x ^ cmp_x) & ~msk_x)) | (|((snap_y ^ cmp_y) & ~msk_y));
   assign all_msk = (&msk_a) & (&msk_b) & (&msk_flg) & (&msk_x) & (&msk_y);

   logic past_rst;
   always_ff @(posedge clk) past_rst <= rst_n;

   AST_RESET_LOW: assert property (@(posedge clk) !past_rst |-> !brk_req); // R1
   AST_NO_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
      !retire |=> !brk_req); // R2
   AST_HIT_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && retire && !diff_any) |=> brk_req); // R10
   AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (retire && diff_any) |=> !brk_req); // R7
   AST_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && retire && all_msk) |=> brk_req); // R8
   AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !brk_req); // R9
endmodule

bind regval_break regval_break_chk #(.ACC_W(ACC_W), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable), .retire(retire),
   .snap_a(snap_a), .snap_b(snap_b), .snap_flg(snap_flg), .snap_x(snap_x), .snap_y(snap_y),
   .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_flg(cmp_flg), .cmp_x(cmp_x), .cmp_y(cmp_y),
   .msk_a(msk_a), .msk_b(msk_b), .msk_flg(msk_flg), .msk_x(msk_x), .msk_y(msk_y),
   .brk_req(brk_req));

// File: tb/regval_break_bench.sv
`timescale 1ns/1ps
module regval_break_bench;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n, enable, retire;
   logic [3:0]  snap_a, snap_b, snap_flg, cmp_a, cmp_b, cmp_flg, msk_a, msk_b, msk_flg;
   logic [15:0] snap_x, snap_y, cmp_x, cmp_y, msk_x, msk_y;
   logic brk_req;

   int n_chk = 0, n_fail = 0;
   int unsigned seed = 32'h5eed_1234;

   regval_break u_regval_break (
      .clk(clk), .rst_n(rst_n), .enable(enable), .retire(retire),
      .snap_a(snap_a), .snap_b(snap_b), .snap_flg(snap_flg), .snap_x(snap_x), .snap_y(snap_y),
      .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_flg(cmp_flg), .cmp_x(cmp_x), .cmp_y(cmp_y),
      .msk_a(msk_a), .msk_b(msk_b), .msk_flg(msk_flg), .msk_x(msk_x), .msk_y(msk_y),
      .brk_req(brk_req));

   function automatic logic exp_hit();
      return enable && retire
         && ((snap_a ^ cmp_a) & ~msk_a) == 4'h0 && ((snap_b ^ cmp_b) & ~msk_b) == 4'h0
         && ((snap_flg ^ cmp_flg) & ~msk_flg) == 4'h0
         && ((snap_x ^ cmp_x) & ~msk_x) == 16'h0 && ((snap_y ^ cmp_y) & ~msk_y) == 16'h0;
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: brk_req=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   // drive at negedge, evaluate at posedge, sample 1 ns later
   task automatic step(input string req, input logic ret);
      logic e;
      @(negedge clk);
      retire = ret;
      #1 e = exp_hit();
      @(posedge clk);
      #1 check(req, brk_req, e);
   endtask

   task automatic match_all();
      snap_a = cmp_a; snap_b = cmp_b; snap_flg = cmp_flg; snap_x = cmp_x; snap_y = cmp_y;
   endtask

   task automatic clear_masks();
      msk_a = '0; msk_b = '0; msk_flg = '0; msk_x = '0; msk_y = '0;
   endtask

   initial begin
      #2000000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      rst_n = 0; enable = 1; retire = 1;
      cmp_a = 4'h5; cmp_b = 4'hA; cmp_flg = 4'b1001; cmp_x = 16'h1234; cmp_y = 16'hBEEF;
      clear_masks(); match_all();
      repeat (3) @(posedge clk);
      #1 check("R1", brk_req, 1'b0);
      @(negedge clk); rst_n = 1; retire = 0;
      @(posedge clk); #1 check("R1", brk_req, 1'b0);

      // R10: single pulse, then back-to-back
      step("R10", 1'b1);
      step("R10", 1'b0);
      step("R10", 1'b1);
      step("R10", 1'b1);
      step("R10", 1'b0);
      // R2: matching snapshot without retire
      step("R2", 1'b0);
      // R3: one-bit mismatch in A, B (top and bottom bits)
      snap_a = cmp_a ^ 4'h8; step("R3", 1'b1); match_all();
      snap_b = cmp_b ^ 4'h1; step("R3", 1'b1); match_all();
      // R4: each flag
      for (int i = 0; i < 4; i++) begin
         snap_flg = cmp_flg ^ (4'h1 << i); step("R4", 1'b1);
         msk_flg = 4'h1 << i; step("R6", 1'b1);
         clear_masks(); match_all();
      end
      // R5: X and Y
      snap_x = cmp_x ^ 16'h8000; step("R5", 1'b1); match_all();
      snap_y = cmp_y ^ 16'h0001; step("R5", 1'b1);
      msk_y = 16'h0001; step("R6", 1'b1); clear_masks(); match_all();
      // R7: mismatch only in last field while others match
      snap_y = cmp_y ^ 16'h0100; step("R7", 1'b1); match_all();
      // R8: all masked, random snapshots
      msk_a = '1; msk_b = '1; msk_flg = '1; msk_x = '1; msk_y = '1;
      for (int i = 0; i < 6; i++) begin
         snap_a = 4'($urandom(seed)); snap_x = 16'($urandom); snap_y = 16'($urandom);
         step("R8", 1'b1);
      end
      clear_masks(); match_all();
      // R9: disabled
      enable = 0; step("R9", 1'b1); step("R9", 1'b1);
      enable = 1; step("R9", 1'b1);

      // random mix
      for (int i = 0; i < 400; i++) begin
         int unsigned r = $urandom;
         cmp_a = 4'($urandom); cmp_b = 4'($urandom); cmp_flg = 4'($urandom);
         cmp_x = 16'($urandom); cmp_y = 16'($urandom);
         msk_a = 4'($urandom) & 4'($urandom); msk_b = 4'($urandom) & 4'($urandom);
         msk_flg = 4'($urandom) & 4'($urandom);
         msk_x = 16'($urandom) & 16'($urandom) & 16'($urandom);
         msk_y = 16'($urandom) & 16'($urandom) & 16'($urandom);
         match_all();
         case (r % 6)
            0: snap_a = snap_a ^ (4'h1 << ($urandom % 4));
            1: snap_b = snap_b ^ (4'h1 << ($urandom % 4));
            2: snap_flg = snap_flg ^ (4'h1 << ($urandom % 4));
            3: snap_x = snap_x ^ (16'h1 << ($urandom % 16));
            4: snap_y = snap_y ^ (16'h1 << ($urandom % 16));
            default: ;
         endcase
         enable = ($urandom % 8) != 0;
         step("R7", ($urandom % 4) != 0);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule